// File: doc/BRIEF.md
# Iterative Bitonic Key Sorter

This block sorts a power-of-two number of unsigned keys kept in its own dual-port RAM, using one compare-and-exchange stage that is reused for every pair. Keys are written in through a load port while the block is idle. A single-cycle `start` pulse then begins a fixed sequence of bitonic steps. Each step visits all N/2 pairs and writes the smaller key of each pair to the lower address. When the last step finishes, `done` pulses and the sorted keys can be read back through the read port.

Pair addresses come from a closed-form formula driven by a pair index `t` and the current step height. Every step uses one of two pairing patterns. In the mirrored pattern, each pair spans a block symmetrically about its centre. In the spread pattern, the two addresses of a pair are half a block apart. All of this is computed with shifts and masks, without a divider. Each pair is read, compared and written back before the next pair is read, so the writes of one step are committed before any read of the following step.

Top module: `bitonic_mem_sorter`

## Requirements
- R1: After reset, `done` is low and the block is idle, so it accepts `start` and load writes.
- R2: While idle, `ld_we` high writes `ld_data` to address `ld_addr`. `rd_data` shows the key at `rd_addr` one clock edge after the address is presented.
- R3: After `done`, the keys read back at addresses 0..N-1 are in non-decreasing unsigned order.
- R4: The sort keeps the contents as a multiset. Duplicates, all-equal inputs, and the values 0 and all-ones come back with their original counts.
- R5: `done` rises on the clock edge exactly 4·(N/2)·L·(L+1)/2 edges after the edge that samples `start`, with L = log2(N). For N=16 this is 320 edges, whatever the data.
- R6: `done` stays high for exactly one cycle.
- R7: `start` has no effect while a sort is running. A second pulse changes neither the completion time nor the result.
- R8: `ld_we` has no effect while a sort is running. The sorted output contains no key written during the sort.
- R9: Every exchange writes to a lower address that is strictly below its partner, and the key written to the lower address is the smaller of the two.
- R10: Steps run as a mirrored step at each height h = 2, 4, …, N. Each mirrored step is followed by spread steps at heights h/2, h/4, …, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Key write enable (idle only) |
| ld_addr | input | log2(N) | Key write address |
| ld_data | input | KEY_W | Key write data |
| start | input | 1 | Start pulse, sampled while idle |
| rd_addr | input | log2(N) | Read-back address |
| rd_data | output | KEY_W | Registered read-back key |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with N=16 and KEY_W=8. This gives L=4 and ten steps, so the full step order is exercised, including the mirrored step that spans the whole array. The narrow keys make duplicates and the 0 and 255 extremes frequent. The same width lets the fixed 320-edge completion time be compared across reversed, sorted, constant, pseudo-random and extreme inputs. Disturbing `start` and `ld_we` mid-sort confirms that neither the schedule nor the memory contents can be disturbed.

// File: rtl/bsort_pkg.sv
package bsort_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_COMP,
    ST_WRITE,
    ST_NEXT,
    ST_DONE
  } sort_state_e;
endpackage

// File: rtl/bsort_ram.sv
// Simple true dual-port RAM, registered reads, block-RAM friendly.
module bsort_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_rd,
  input  logic [AW-1:0] b_addr,
  input  logic          b_we,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_rd
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wd;
    if (b_we) mem[b_addr] <= b_wd;
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
  end
endmodule

// File: rtl/bsort_steps.sv
// Step schedule: mirrored step at each height, then spread steps halving to 2.
module bsort_steps #(
  parameter int LOG_N = 4,
  localparam int LW = $clog2(LOG_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init,
  input  logic          adv,
  output logic [LW-1:0] lh,
  output logic          flip,
  output logic          last
);
  logic [LW-1:0] stage_q;

  assign last = (lh == LW'(1)) && (stage_q == LW'(LOG_N));

  always_ff @(posedge clk) begin
    if (rst || init) begin
      stage_q <= LW'(1);
      lh      <= LW'(1);
      flip    <= 1'b1;
    end else if (adv && !last) begin
      if (lh == LW'(1)) begin
        stage_q <= stage_q + LW'(1);
        lh      <= stage_q + LW'(1);
        flip    <= 1'b1;
      end else begin
        lh   <= lh - LW'(1);
        flip <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bsort_addr.sv
// Closed-form pair address generator (shifts and masks only).
module bsort_addr #(
  parameter int AW = 4,
  localparam int TW = AW - 1,
  localparam int LW = $clog2(AW + 1)
) (
  input  logic [TW-1:0] t,
  input  logic [LW-1:0] lh,
  input  logic          flip,
  output logic [AW-1:0] lo,
  output logic [AW-1:0] hi
);
  logic [AW-1:0] tw, half, m, q;

  always_comb begin
    tw   = AW'(t);
    half = AW'(1) << (lh - LW'(1));
    m    = tw & (half - AW'(1));
    q    = (tw >> (lh - LW'(1))) << lh;
    lo   = q + m;
    hi   = flip ? (q + (half << 1) - AW'(1) - m) : (q + m + half);
  end
endmodule

// File: rtl/bitonic_mem_sorter.sv
module bitonic_mem_sorter #(
  parameter int N     = 16,
  parameter int KEY_W = 8,
  localparam int AW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic [AW-1:0]    ld_addr,
  input  logic [KEY_W-1:0] ld_data,
  input  logic             start,
  input  logic [AW-1:0]    rd_addr,
  output logic [KEY_W-1:0] rd_data,
  output logic             done
);
  import bsort_pkg::*;

  localparam int TW    = AW - 1;
  localparam int LW    = $clog2(AW + 1);
  localparam int PAIRS = N / 2;

  sort_state_e      state_q;
  logic [TW-1:0]    t_q;
  logic [KEY_W-1:0] lo_key_q, hi_key_q;
  logic             done_q;
  logic [LW-1:0]    lh;
  logic             flip, last_step;
  logic [AW-1:0]    lo_addr, hi_addr;
  logic             idle, t_last;
  logic [AW-1:0]    a_addr, b_addr;
  logic             a_we, b_we;
  logic [KEY_W-1:0] a_wd, a_rd, b_rd;

  assign idle   = (state_q == ST_IDLE);
  assign t_last = (t_q == TW'(PAIRS - 1));

  bsort_steps #(.LOG_N(AW)) steps_i (
    .clk  (clk),
    .rst  (rst),
    .init (idle && start),
    .adv  ((state_q == ST_NEXT) && t_last),
    .lh   (lh),
    .flip (flip),
    .last (last_step)
  );

  bsort_addr #(.AW(AW)) addr_i (
    .t    (t_q),
    .lh   (lh),
    .flip (flip),
    .lo   (lo_addr),
    .hi   (hi_addr)
  );

  // Port A: load / lower key. Port B: read-back / upper key.
  assign a_addr = idle ? ld_addr : lo_addr;
  assign a_we   = idle ? ld_we : (state_q == ST_WRITE);
  assign a_wd   = idle ? ld_data : lo_key_q;
  assign b_addr = idle ? rd_addr : hi_addr;
  assign b_we   = (state_q == ST_WRITE);

  bsort_ram #(.AW(AW), .DW(KEY_W)) ram_i (
    .clk    (clk),
    .a_addr (a_addr),
    .a_we   (a_we),
    .a_wd   (a_wd),
    .a_rd   (a_rd),
    .b_addr (b_addr),
    .b_we   (b_we),
    .b_wd   (hi_key_q),
    .b_rd   (b_rd)
  );

  assign rd_data = b_rd;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      t_q      <= '0;
      lo_key_q <= '0;
      hi_key_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_READ;
          t_q     <= '0;
        end
        ST_READ:  state_q <= ST_COMP;
        ST_COMP: begin
          lo_key_q <= (a_rd <= b_rd) ? a_rd : b_rd;
          hi_key_q <= (a_rd <= b_rd) ? b_rd : a_rd;
          state_q  <= ST_WRITE;
        end
        ST_WRITE: state_q <= ST_NEXT;
        ST_NEXT: begin
          t_q <= t_q + TW'(1);
          if (t_last && last_step) begin
            state_q <= ST_DONE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsort_chk.sv
module bsort_chk #(
  parameter int N     = 16,
  parameter int KEY_W = 8,
  localparam int AW   = $clog2(N)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  done,
  input bsort_pkg::sort_state_e state,
  input logic [AW-1:0]         lo_addr,
  input logic [AW-1:0]         hi_addr,
  input logic [KEY_W-1:0]      lo_key,
  input logic [KEY_W-1:0]      hi_key
);
  import bsort_pkg::*;

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_read_flow: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ) |=> (state == ST_COMP));

  a_r7_write_flow: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE) |=> (state == ST_NEXT));

  a_r9_addr_order: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE) |-> (lo_addr < hi_addr));

  a_r9_min_low: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE) |-> (lo_key <= hi_key));

  a_r5_done_after_next: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($past(state) == ST_NEXT));
endmodule

bind bitonic_mem_sorter bsort_chk #(.N(N), .KEY_W(KEY_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .done    (done),
  .state   (state_q),
  .lo_addr (lo_addr),
  .hi_addr (hi_addr),
  .lo_key  (lo_key_q),
  .hi_key  (hi_key_q)
);

// File: tb/bitonic_mem_sorter_tb_top.sv
`timescale 1ns/1ps
module bitonic_mem_sorter_tb_top;
  localparam int N      = 16;
  localparam int KW     = 8;
  localparam int AW     = $clog2(N);
  localparam int EXPCYC = 4 * (N / 2) * AW * (AW + 1) / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_we = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [KW-1:0] ld_data = '0;
  logic          start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [KW-1:0] rd_data;
  logic          done;

  int checks = 0;
  int errors = 0;
  logic [KW-1:0] keys [N];
  logic [KW-1:0] want [N];

  always #2.5 clk = ~clk;

  bitonic_mem_sorter #(.N(N), .KEY_W(KW)) dut_i (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .start(start), .rd_addr(rd_addr), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic build_ref();
    for (int i = 0; i < N; i++) want[i] = keys[i];
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N - 1 - i; j++)
        if (want[j] > want[j+1]) begin
          logic [KW-1:0] tmp = want[j];
          want[j] = want[j+1];
          want[j+1] = tmp;
        end
  endtask

  task automatic load_keys();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = AW'(i); ld_data = keys[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic read_check(input string req);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      rd_addr = AW'(i);
      @(negedge clk);
      chk(rd_data == want[i], req, int'(rd_data), int'(want[i]));
    end
  endtask

  task automatic run_sort(input bit poke_start, input bit poke_load);
    int cyc;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
      start = (poke_start && cyc == 50);
      ld_we = (poke_load && cyc == 70);
      ld_addr = '0;
      ld_data = 8'h5A;
    end
    start = 1'b0; ld_we = 1'b0;
    chk(cyc == EXPCYC, "R5 cycle count", cyc, EXPCYC);
    @(negedge clk);
    chk(done == 1'b0, "R6 done pulse width", int'(done), 0);
  endtask

  task automatic sort_and_check(input string req);
    build_ref();
    load_keys();
    run_sort(1'b0, 1'b0);
    read_check(req);
  endtask

  task automatic t_reset_load();
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    for (int i = 0; i < N; i++) keys[i] = KW'(i * 7 + 3);
    for (int i = 0; i < N; i++) want[i] = keys[i];
    load_keys();
    read_check("R2 load readback");
  endtask

  task automatic t_reverse();
    for (int i = 0; i < N; i++) keys[i] = KW'(N - 1 - i);
    sort_and_check("R3 reversed input");
  endtask

  task automatic t_sorted();
    for (int i = 0; i < N; i++) keys[i] = KW'(i * 3);
    sort_and_check("R3 presorted input (R10 schedule)");
  endtask

  task automatic t_equal();
    for (int i = 0; i < N; i++) keys[i] = 8'h42;
    sort_and_check("R4 all equal");
  endtask

  task automatic t_mixed();
    int s = 12345;
    for (int i = 0; i < N; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      keys[i] = KW'(s >> 16) & 8'h1F;
    end
    sort_and_check("R4 duplicates R9 min low");
  endtask

  task automatic t_extremes();
    for (int i = 0; i < N; i++) keys[i] = (i % 2 == 0) ? 8'hFF : 8'h00;
    sort_and_check("R4 extremes");
  endtask

  task automatic t_start_ignored();
    for (int i = 0; i < N; i++) keys[i] = KW'((i * 11) % 17);
    build_ref();
    load_keys();
    run_sort(1'b1, 1'b0);
    read_check("R7 start during sort");
  endtask

  task automatic t_load_ignored();
    for (int i = 0; i < N; i++) keys[i] = KW'(200 - i * 9);
    build_ref();
    load_keys();
    run_sort(1'b0, 1'b1);
    read_check("R8 load during sort");
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_load();
    t_reverse();
    t_sorted();
    t_equal();
    t_mixed();
    t_extremes();
    t_start_ignored();
    t_load_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule